// File: doc/BRIEF.md
# Base-and-Bound Address Translator

This block sits between a processor's address generation and its memory port. It relocates each memory access by adding a base register to the program's effective address. It also protects memory by comparing that effective address against a bound register. An access that passes the check leaves the block one cycle later as a valid physical address. An access that fails produces a one-cycle fault strobe, which the processor turns into a trap to the operating system, and no physical address is issued for it.

A privilege bit selects between user mode and supervisor mode. Only supervisor code may load the base and bound registers. When user code attempts such a load, the block drops it and raises a separate privilege-fault strobe. Two control inputs move the processor into supervisor mode and back to user mode.

Top module: `reloc_guard`

## Requirements
- R1: When `acc_vld_i` is high on a rising edge and the access is legal, then after that edge `pa_vld_o` is high and `pa_o` equals `acc_ea_i` plus the base register, truncated to ADDR_W bits. Translation uses the register values held before that edge.
- R2: An access is legal only when `acc_ea_i` is less than or equal to the bound register. An address exactly equal to the bound is legal.
- R3: When `acc_ea_i` is greater than the bound, `bnd_fault_o` is high for the single cycle after the access edge, `pa_vld_o` is low, and `pa_o` is zero.
- R4: When `acc_ea_i` plus the base carries out of ADDR_W bits, the access is treated as a bounds violation, with the same outputs as in R3.
- R5: The privilege bit is shown on `sup_mode_o`, where 1 means supervisor and 0 means user.
- R6: When `enter_sup_i` is high at an edge, the block is in supervisor mode after that edge. When `leave_sup_i` alone is high, the block is in user mode after that edge. If both inputs are high at the same edge, `enter_sup_i` wins.
- R7: In supervisor mode, `cfg_wr_i` loads `cfg_data_i` into the base register when `cfg_sel_i` is 0, and into the bound register when `cfg_sel_i` is 1. The new value applies to accesses from the next edge onward. An access at the same edge as the load still uses the old value. The write is checked against the mode held before the edge.
- R8: In user mode, `cfg_wr_i` leaves both registers unchanged and raises `priv_fault_o` for the one cycle after that edge. A supervisor write never raises `priv_fault_o`.
- R9: After reset the block is in supervisor mode and the base and bound registers are both zero. An access to address 0 is therefore legal and maps to 0, while an access to address 1 faults.
- R10: A cycle with `acc_vld_i` low produces neither `pa_vld_o` nor `bnd_fault_o`, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_vld_i | input | 1 | An access is presented this cycle |
| acc_ea_i | input | ADDR_W | Effective address of the access |
| cfg_wr_i | input | 1 | Request to load a relocation register |
| cfg_sel_i | input | 1 | Register to load: 0 selects base, 1 selects bound |
| cfg_data_i | input | ADDR_W | Value to load |
| enter_sup_i | input | 1 | Switch to supervisor mode |
| leave_sup_i | input | 1 | Return to user mode |
| pa_vld_o | output | 1 | The translated address is valid |
| pa_o | output | ADDR_W | Physical address, zero when not valid |
| bnd_fault_o | output | 1 | One-cycle strobe for a bounds violation |
| priv_fault_o | output | 1 | One-cycle strobe for a rejected user-mode write |
| sup_mode_o | output | 1 | Current privilege bit |

## Verification
The bench builds the translator with ADDR_W set to 8, so the whole address space has only 256 entries. This lets one sweep drive every effective address against a fixed base and bound. The sweep crosses the inclusive bound edge and the carry-out boundary in a single pass. The 8-bit width also makes the all-ones corner cheap to reach: with a large base, the top address that still fits and the first address that wraps sit side by side. The sweep and the hand-written cases all use the same scoreboard.

// File: rtl/rg_pkg.sv
package rg_pkg;

    // Privilege bit encoding
    typedef enum logic {
        MODE_USER = 1'b0,
        MODE_SUP  = 1'b1
    } mode_e;

    // Register selector for configuration writes
    typedef enum logic {
        SEL_BASE  = 1'b0,
        SEL_LIMIT = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/rg_mode.sv
module rg_mode
    import rg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  enter_i,
    input  logic  leave_i,
    input  logic  wr_req_i,
    output mode_e mode_o,
    output logic  wr_grant_o,
    output logic  wr_deny_o
);

    typedef struct packed {
        mode_e mode;
    } mode_state_t;

    mode_state_t st_d, st_q;

    // Next state: entering supervisor has priority over leaving it
    always_comb begin
        st_d = st_q;
        if (enter_i) begin
            st_d.mode = MODE_SUP;
        end else if (leave_i) begin
            st_d.mode = MODE_USER;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= MODE_SUP;
        end else begin
            st_q <= st_d;
        end
    end

    // The write check uses the mode held before the edge
    always_comb begin
        mode_o     = st_q.mode;
        wr_grant_o = wr_req_i && (st_q.mode == MODE_SUP);
        wr_deny_o  = wr_req_i && (st_q.mode == MODE_USER);
    end

endmodule

// File: rtl/rg_regs.sv
module rg_regs
    import rg_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  reg_sel_e          sel_i,
    input  logic [ADDR_W-1:0] data_i,
    output logic [ADDR_W-1:0] base_o,
    output logic [ADDR_W-1:0] limit_o
);

    localparam int NREG = 2;

    typedef logic [ADDR_W-1:0] word_t;

    typedef struct packed {
        word_t [NREG-1:0] r;
    } regs_state_t;

    regs_state_t st_d, st_q;

    // One write-enable per register, decoded from the selector
    logic [NREG-1:0] hit;

    for (genvar g = 0; g < NREG; g++) begin : g_dec
        assign hit[g] = wr_en_i && (int'(sel_i) == g);
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            if (hit[i]) begin
                st_d.r[i] = data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign base_o  = st_q.r[int'(SEL_BASE)];
    assign limit_o = st_q.r[int'(SEL_LIMIT)];

endmodule

// File: rtl/rg_check.sv
module rg_check #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] ea_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] limit_i,
    output logic [ADDR_W-1:0] pa_o,
    output logic              legal_o,
    output logic              over_limit_o,
    output logic              carry_o
);

    localparam int SUM_W = ADDR_W + 1;

    logic [SUM_W-1:0] sum;

    // The adder and the comparator work side by side, not one after the other
    always_comb begin
        sum          = {1'b0, ea_i} + {1'b0, base_i};
        carry_o      = sum[SUM_W-1];
        over_limit_o = (ea_i > limit_i);
        legal_o      = !carry_o && !over_limit_o;
        pa_o         = sum[ADDR_W-1:0];
    end

endmodule

// File: rtl/reloc_guard.sv
module reloc_guard
    import rg_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_vld_i,
    input  logic [ADDR_W-1:0] acc_ea_i,
    input  logic              cfg_wr_i,
    input  logic              cfg_sel_i,
    input  logic [ADDR_W-1:0] cfg_data_i,
    input  logic              enter_sup_i,
    input  logic              leave_sup_i,
    output logic              pa_vld_o,
    output logic [ADDR_W-1:0] pa_o,
    output logic              bnd_fault_o,
    output logic              priv_fault_o,
    output logic              sup_mode_o
);

    typedef struct packed {
        logic              pa_vld;
        logic [ADDR_W-1:0] pa;
        logic              bnd_fault;
        logic              priv_fault;
    } resp_t;

    mode_e             mode_w;
    logic              grant_w;
    logic              deny_w;
    logic [ADDR_W-1:0] base_w;
    logic [ADDR_W-1:0] limit_w;
    logic [ADDR_W-1:0] sum_w;
    logic              legal_w;
    logic              over_w;
    logic              carry_w;

    resp_t rsp_d, rsp_q;

    rg_mode u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter_i    (enter_sup_i),
        .leave_i    (leave_sup_i),
        .wr_req_i   (cfg_wr_i),
        .mode_o     (mode_w),
        .wr_grant_o (grant_w),
        .wr_deny_o  (deny_w)
    );

    rg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (grant_w),
        .sel_i   (reg_sel_e'(cfg_sel_i)),
        .data_i  (cfg_data_i),
        .base_o  (base_w),
        .limit_o (limit_w)
    );

    rg_check #(.ADDR_W(ADDR_W)) u_check (
        .ea_i         (acc_ea_i),
        .base_i       (base_w),
        .limit_i      (limit_w),
        .pa_o         (sum_w),
        .legal_o      (legal_w),
        .over_limit_o (over_w),
        .carry_o      (carry_w)
    );

    // Either cause of a violation leads to the same fault
    logic violation;
    assign violation = over_w || carry_w;

    always_comb begin
        rsp_d            = '0;
        rsp_d.pa_vld     = acc_vld_i && legal_w;
        rsp_d.pa         = (acc_vld_i && legal_w) ? sum_w : '0;
        rsp_d.bnd_fault  = acc_vld_i && violation;
        rsp_d.priv_fault = deny_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign pa_vld_o     = rsp_q.pa_vld;
    assign pa_o         = rsp_q.pa;
    assign bnd_fault_o  = rsp_q.bnd_fault;
    assign priv_fault_o = rsp_q.priv_fault;
    assign sup_mode_o   = (mode_w == MODE_SUP);

endmodule

// File: rtl/reloc_guard_chk.sv
module reloc_guard_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_vld_i,
    input logic              cfg_wr_i,
    input logic              enter_sup_i,
    input logic              leave_sup_i,
    input logic              pa_vld_o,
    input logic              bnd_fault_o,
    input logic              priv_fault_o,
    input logic              sup_mode_o,
    input logic [ADDR_W-1:0] base_q,
    input logic [ADDR_W-1:0] limit_q
);

    assert_vld_from_access_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pa_vld_o |-> $past(acc_vld_i));

    assert_fault_blocks_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_fault_o |-> !pa_vld_o);

    assert_fault_from_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_fault_o |-> $past(acc_vld_i));

    assert_enter_sets_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        enter_sup_i |=> sup_mode_o);

    assert_leave_clears_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (leave_sup_i && !enter_sup_i) |=> !sup_mode_o);

    assert_user_write_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && !sup_mode_o) |=> ($stable(base_q) && $stable(limit_q)));

    assert_user_write_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && !sup_mode_o) |=> priv_fault_o);

    assert_sup_write_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && sup_mode_o) |=> !priv_fault_o);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_vld_i |=> (!pa_vld_o && !bnd_fault_o));

endmodule

bind reloc_guard reloc_guard_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_vld_i    (acc_vld_i),
    .cfg_wr_i     (cfg_wr_i),
    .enter_sup_i  (enter_sup_i),
    .leave_sup_i  (leave_sup_i),
    .pa_vld_o     (pa_vld_o),
    .bnd_fault_o  (bnd_fault_o),
    .priv_fault_o (priv_fault_o),
    .sup_mode_o   (sup_mode_o),
    .base_q       (base_w),
    .limit_q      (limit_w)
);

// File: tb/reloc_guard_tb_top.sv
module reloc_guard_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         acc_vld_i = 1'b0;
    logic [W-1:0] acc_ea_i = '0;
    logic         cfg_wr_i = 1'b0;
    logic         cfg_sel_i = 1'b0;
    logic [W-1:0] cfg_data_i = '0;
    logic         enter_sup_i = 1'b0;
    logic         leave_sup_i = 1'b0;
    logic         pa_vld_o;
    logic [W-1:0] pa_o;
    logic         bnd_fault_o;
    logic         priv_fault_o;
    logic         sup_mode_o;

    always #10 clk = ~clk;

    reloc_guard #(.ADDR_W(W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_vld_i    (acc_vld_i),
        .acc_ea_i     (acc_ea_i),
        .cfg_wr_i     (cfg_wr_i),
        .cfg_sel_i    (cfg_sel_i),
        .cfg_data_i   (cfg_data_i),
        .enter_sup_i  (enter_sup_i),
        .leave_sup_i  (leave_sup_i),
        .pa_vld_o     (pa_vld_o),
        .pa_o         (pa_o),
        .bnd_fault_o  (bnd_fault_o),
        .priv_fault_o (priv_fault_o),
        .sup_mode_o   (sup_mode_o)
    );

    typedef struct {
        int           cyc;
        logic         vld;
        logic [W-1:0] pa;
        logic         bf;
        logic         pf;
        logic         md;
        string        tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc = 0;

    // Reference state, kept from the requirements
    logic [W-1:0] m_base = '0;
    logic [W-1:0] m_lim  = '0;
    logic         m_mode = 1'b1;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic step(input logic a, input logic [W-1:0] ea, input logic w,
                        input logic s, input logic [W-1:0] d, input logic en,
                        input logic lv, input string tag);
        exp_t     e;
        logic [W:0] sum;
        @(negedge clk);
        acc_vld_i   = a;
        acc_ea_i    = ea;
        cfg_wr_i    = w;
        cfg_sel_i   = s;
        cfg_data_i  = d;
        enter_sup_i = en;
        leave_sup_i = lv;
        sum   = {1'b0, ea} + {1'b0, m_base};
        e.cyc = cyc;
        e.vld = a && !sum[W] && (ea <= m_lim);
        e.pa  = e.vld ? sum[W-1:0] : '0;
        e.bf  = a && !e.vld;
        e.pf  = w && !m_mode;
        if (w && m_mode) begin
            if (s) m_lim = d;
            else   m_base = d;
        end
        m_mode = en ? 1'b1 : (lv ? 1'b0 : m_mode);
        e.md  = m_mode;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic acc(input logic [W-1:0] ea, input string tag);
        step(1'b1, ea, 1'b0, 1'b0, '0, 1'b0, 1'b0, tag);
    endtask

    task automatic wr(input logic s, input logic [W-1:0] d, input string tag);
        step(1'b0, '0, 1'b1, s, d, 1'b0, 1'b0, tag);
    endtask

    // Monitor: compare the oldest item once its cycle has passed
    always @(negedge clk) begin
        if (q.size() > 0 && q[0].cyc < cyc) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if ({pa_vld_o, pa_o, bnd_fault_o, priv_fault_o, sup_mode_o} !==
                {e.vld, e.pa, e.bf, e.pf, e.md}) begin
                n_bad++;
                $display("FAIL %s: got vld=%0b pa=%02h bf=%0b pf=%0b sup=%0b, expected vld=%0b pa=%02h bf=%0b pf=%0b sup=%0b",
                         e.tag, pa_vld_o, pa_o, bnd_fault_o, priv_fault_o, sup_mode_o,
                         e.vld, e.pa, e.bf, e.pf, e.md);
            end
        end
    end

    initial begin
        #(20 * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state at the ports
        n_chk++;
        if ({pa_vld_o, bnd_fault_o, priv_fault_o, sup_mode_o} !== 4'b0001) begin
            n_bad++;
            $display("FAIL R9: got vld=%0b bf=%0b pf=%0b sup=%0b, expected 0 0 0 1",
                     pa_vld_o, bnd_fault_o, priv_fault_o, sup_mode_o);
        end
        rst_n = 1'b1;

        acc(8'h00, "R9 zero base/bound legal");
        acc(8'h01, "R9 zero bound faults");

        wr(1'b0, 8'h30, "R7 load base");
        wr(1'b1, 8'h40, "R7 load bound");
        acc(8'h10, "R1 relocate");
        acc(8'h40, "R2 at bound");
        acc(8'h41, "R3 above bound");
        acc(8'h3F, "R2 below bound");

        // R7: access beside a load uses the old bound
        step(1'b1, 8'h30, 1'b1, 1'b1, 8'h20, 1'b0, 1'b0, "R7 same-edge old bound");
        acc(8'h30, "R7 new bound applies");

        wr(1'b0, 8'hF0, "R7 big base");
        wr(1'b1, 8'hFF, "R7 max bound");
        acc(8'h0F, "R4 top without carry");
        acc(8'h10, "R4 carry out");
        acc(8'hFF, "R4 carry at max");

        step(1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b1, "R6 leave supervisor");
        wr(1'b0, 8'h00, "R8 user base write");
        acc(8'h05, "R8 base unchanged");
        wr(1'b1, 8'h00, "R8 user bound write");
        acc(8'h05, "R8 bound unchanged");
        acc(8'h20, "R8 carry still from old base");

        step(1'b0, '0, 1'b0, 1'b0, '0, 1'b1, 1'b1, "R6 enter wins");
        step(1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b1, "R5 user mode bit");
        step(1'b0, '0, 1'b0, 1'b0, '0, 1'b1, 1'b0, "R5 supervisor mode bit");

        step(1'b0, 8'hAA, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R10 idle");
        step(1'b0, 8'hFF, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R10 idle high addr");

        wr(1'b0, 8'h90, "R7 sweep base");
        wr(1'b1, 8'h60, "R7 sweep bound");
        for (int i = 0; i < 256; i++) begin
            acc(W'(i), "R2 sweep");
        end

        step(1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R10 final idle");
        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule